// File: doc/BRIEF.md
# Processor I/O Cycle Router

This block sits between the processor's I/O-space request path and the destinations that can answer an I/O cycle. Each accepted request goes to exactly one destination. The configuration-address register is held inside the router and answered locally. A configuration-data access is handed to the configuration space. A small set of fixed display-adapter port ranges goes to the integrated graphics function when that function is enabled. A programmable 4 KB-granular window goes to the PCI Express port. Everything else takes the default legacy downstream link. Forwarded addresses are passed on unchanged, and every forwarded I/O cycle is non-posted: the router accepts nothing new until that destination returns a completion.

I/O or configuration requests that arrive inbound from a downstream link should never happen. When one does, the router does not execute it. Read or write, it is turned into a memory read at a fixed address, so a completion arises naturally. The completion that goes back to the originating link always carries Unsupported Request status.

Top module: `io_cycle_router`

## Requirements
- R1: After reset, `req_ready` and `in_ready` are high, all four destination strobes, `cpl_valid`, `mem_rd_req` and `up_cpl_valid` are low, and the configuration-address register reads as zero.
- R2: A request to dword 0xCF8 with `req_be` = 4'b1111 is claimed locally. No destination strobe fires, and `cpl_valid` rises one cycle after acceptance with status 2'b00 (success). A write stores `req_wdata`, and a later read returns the stored value on `cpl_rdata`. A partial-byte access to 0xCF8 is not claimed and routes by R4 to R7.
- R3: A request to dword 0xCFC (any byte enables) raises `cfg_req` only while bit 31 of the configuration-address register is set. Otherwise it routes by R4 to R7.
- R4: While `gfx_en` is high, requests whose dword address lies in 0x3B0–0x3BB or 0x3C0–0x3DF raise `gfx_req`. While `gfx_en` is low, those addresses route by R5 to R7.
- R5: While `pcie_io_en` is high, a request with `pcie_base` ≤ address[15:12] ≤ `pcie_limit` raises `pcie_req`. If `pcie_base` is greater than `pcie_limit`, or `pcie_io_en` is low, the window matches nothing.
- R6: Priority is configuration (R2, R3), then graphics, then the PCI Express window, then the default link.
- R7: A request that matches no other rule raises `legacy_req`.
- R8: During a destination strobe, `fwd_addr`, `fwd_be`, `fwd_write` and `fwd_wdata` equal the accepted request without translation.
- R9: A strobe is a single-cycle pulse, one cycle after acceptance. For a forwarded read or write, `req_ready` stays low and further requests are ignored until `tgt_cpl_valid` is seen. One cycle later, `cpl_valid` pulses with `tgt_cpl_status` and `tgt_cpl_data`.
- R10: An accepted inbound request, whether `in_write` is high or low, produces a one-cycle `mem_rd_req` with `mem_rd_addr` = 0x000C0000 one cycle later. `in_ready` stays low until `mem_rd_done`.
- R11: One cycle after `mem_rd_done`, `up_cpl_valid` pulses with `up_cpl_status` = 2'b01 (Unsupported Request) and `up_cpl_src` equal to the captured `in_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor I/O request present |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | 16 | I/O byte address, dword aligned |
| req_be | input | 4 | Byte enables within the dword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| gfx_en | input | 1 | Integrated graphics decode enable |
| pcie_io_en | input | 1 | Enables I/O routing to PCI Express |
| pcie_base | input | 4 | Window base, address bits 15:12 |
| pcie_limit | input | 4 | Window limit, address bits 15:12 |
| cfg_req | output | 1 | Strobe to configuration space |
| gfx_req | output | 1 | Strobe to graphics |
| pcie_req | output | 1 | Strobe to PCI Express port |
| legacy_req | output | 1 | Strobe to legacy link |
| fwd_addr | output | 16 | Forwarded address |
| fwd_be | output | 4 | Forwarded byte enables |
| fwd_write | output | 1 | Forwarded direction |
| fwd_wdata | output | 32 | Forwarded write data |
| tgt_cpl_valid | input | 1 | Completion from the addressed destination |
| tgt_cpl_status | input | 2 | Destination completion status |
| tgt_cpl_data | input | 32 | Destination read data |
| cpl_valid | output | 1 | Completion to processor |
| cpl_status | output | 2 | 2'b00 success, 2'b01 unsupported |
| cpl_rdata | output | 32 | Read data to processor |
| in_valid | input | 1 | Inbound I/O or configuration request |
| in_ready | output | 1 | Inbound path idle |
| in_write | input | 1 | Inbound request was a write |
| in_src | input | 1 | Originating link (0 legacy, 1 PCI Express) |
| mem_rd_req | output | 1 | Substitute memory read strobe |
| mem_rd_addr | output | 32 | Substitute memory read address |
| mem_rd_done | input | 1 | Substitute memory read finished |
| up_cpl_valid | output | 1 | Completion to originating link |
| up_cpl_status | output | 2 | Always Unsupported Request |
| up_cpl_src | output | 1 | Link that receives the completion |

## Verification
The hardest case to reach from the ports is the window of a pending non-posted cycle. A new request offered then must be ignored, and the completion status must come from the destination rather than from the router. The stimulus holds the completion back for several cycles, drives `req_valid` during that gap and watches that no strobe fires. It then returns an Unsupported status on the destination completion and looks for it on `cpl_valid`. The configuration-data claim depends on internal state, so it is reached by first writing the configuration-address register, toggling bit 31 through that register's own dword port.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

  typedef enum logic [2:0] {
    DST_LOCAL  = 3'd0,
    DST_CFG    = 3'd1,
    DST_GFX    = 3'd2,
    DST_PCIE   = 3'd3,
    DST_LEGACY = 3'd4
  } dest_e;

  localparam logic [1:0] CPL_SC = 2'b00;
  localparam logic [1:0] CPL_UR = 2'b01;

  // strobe vector bit positions {cfg, gfx, pcie, legacy}
  localparam int STB_CFG    = 3;
  localparam int STB_GFX    = 2;
  localparam int STB_PCIE   = 1;
  localparam int STB_LEGACY = 0;
  localparam int NSTB       = 4;

endpackage

// File: rtl/io_addr_decoder.sv
module io_addr_decoder
  import io_route_pkg::*;
#(
  parameter int              AW            = 16,
  parameter int              WIN_LSB       = 12,
  parameter int              NGFX          = 2,
  parameter logic [AW-1:0]   CFG_ADDR_PORT = 16'h0CF8,
  parameter logic [AW-1:0]   CFG_DATA_PORT = 16'h0CFC,
  parameter logic [NGFX*AW-1:0] GFX_LO     = {16'h03C0, 16'h03B0},
  parameter logic [NGFX*AW-1:0] GFX_HI     = {16'h03DF, 16'h03BB}
) (
  input  logic [AW-1:2]      dw_addr,
  input  logic [3:0]         be,
  input  logic               cfg_enable,
  input  logic               gfx_en,
  input  logic               pcie_io_en,
  input  logic [AW-WIN_LSB-1:0] pcie_base,
  input  logic [AW-WIN_LSB-1:0] pcie_limit,
  output dest_e              dest
);

  localparam int DWW = AW - 2;

  logic [NGFX-1:0] gfx_hit;
  logic            cfg_addr_hit;
  logic            cfg_data_hit;
  logic            win_hit;

  generate
    for (genvar g = 0; g < NGFX; g++) begin : g_gfx_rng
      assign gfx_hit[g] = (dw_addr >= GFX_LO[g*AW+2 +: DWW]) &&
                          (dw_addr <= GFX_HI[g*AW+2 +: DWW]);
    end
  endgenerate

  assign cfg_addr_hit = (dw_addr == CFG_ADDR_PORT[AW-1:2]) && (be == 4'hF);
  assign cfg_data_hit = (dw_addr == CFG_DATA_PORT[AW-1:2]) && cfg_enable;
  assign win_hit      = pcie_io_en &&
                        (dw_addr[AW-1:WIN_LSB] >= pcie_base) &&
                        (dw_addr[AW-1:WIN_LSB] <= pcie_limit);

  always_comb begin
    if (cfg_addr_hit)                dest = DST_LOCAL;
    else if (cfg_data_hit)           dest = DST_CFG;
    else if (gfx_en && |gfx_hit)     dest = DST_GFX;
    else if (win_hit)                dest = DST_PCIE;
    else                             dest = DST_LEGACY;
  end

endmodule

// File: rtl/io_cfg_addr_reg.sv
module io_cfg_addr_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/io_req_tracker.sv
module io_req_tracker
  import io_route_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [3:0]      req_be,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  input  dest_e           dest,
  input  logic [DW-1:0]   cfg_q,
  output logic            cfg_wr_en,
  output logic [NSTB-1:0] strobe,
  output logic [AW-1:0]   fwd_addr,
  output logic [3:0]      fwd_be,
  output logic            fwd_write,
  output logic [DW-1:0]   fwd_wdata,
  input  logic            tgt_cpl_valid,
  input  logic [1:0]      tgt_cpl_status,
  input  logic [DW-1:0]   tgt_cpl_data,
  output logic            cpl_valid,
  output logic [1:0]      cpl_status,
  output logic [DW-1:0]   cpl_rdata
);

  typedef enum logic {TRK_IDLE, TRK_WAIT} trk_e;

  trk_e            state_q, state_d;
  logic [NSTB-1:0] strobe_d;
  logic            cpl_valid_d;
  logic [1:0]      cpl_status_d;
  logic [DW-1:0]   cpl_rdata_d;
  logic            accept;
  logic            fwd_load;

  assign req_ready = (state_q == TRK_IDLE);
  assign accept    = req_valid && req_ready;
  assign fwd_load  = accept && (dest != DST_LOCAL);
  assign cfg_wr_en = accept && (dest == DST_LOCAL) && req_write;

  always_comb begin
    state_d      = state_q;
    strobe_d     = '0;
    cpl_valid_d  = 1'b0;
    cpl_status_d = cpl_status;
    cpl_rdata_d  = cpl_rdata;
    if (accept) begin
      if (dest == DST_LOCAL) begin
        cpl_valid_d  = 1'b1;
        cpl_status_d = CPL_SC;
        cpl_rdata_d  = req_write ? '0 : cfg_q;
      end else begin
        state_d = TRK_WAIT;
        unique case (dest)
          DST_CFG:  strobe_d[STB_CFG]    = 1'b1;
          DST_GFX:  strobe_d[STB_GFX]    = 1'b1;
          DST_PCIE: strobe_d[STB_PCIE]   = 1'b1;
          default:  strobe_d[STB_LEGACY] = 1'b1;
        endcase
      end
    end
    if (state_q == TRK_WAIT && tgt_cpl_valid) begin
      state_d      = TRK_IDLE;
      cpl_valid_d  = 1'b1;
      cpl_status_d = tgt_cpl_status;
      cpl_rdata_d  = tgt_cpl_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TRK_IDLE;
      strobe     <= '0;
      cpl_valid  <= 1'b0;
      cpl_status <= CPL_SC;
      cpl_rdata  <= '0;
    end else begin
      state_q    <= state_d;
      strobe     <= strobe_d;
      cpl_valid  <= cpl_valid_d;
      cpl_status <= cpl_status_d;
      cpl_rdata  <= cpl_rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_addr  <= '0;
      fwd_be    <= '0;
      fwd_write <= 1'b0;
      fwd_wdata <= '0;
    end else if (fwd_load) begin
      fwd_addr  <= req_addr;
      fwd_be    <= req_be;
      fwd_write <= req_write;
      fwd_wdata <= req_wdata;
    end
  end

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  // R9
  busy_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |-> !req_ready);

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |=> !(|strobe));

  // R2
  local_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dest == DST_LOCAL) |=> (cpl_valid && cpl_status == CPL_SC && !(|strobe)));

  // R8
  fwd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_load |=> (fwd_addr == $past(req_addr) && fwd_be == $past(req_be)));

endmodule

// File: rtl/io_inbound_conv.sv
module io_inbound_conv
  import io_route_pkg::*;
#(
  parameter int          SRC_W       = 1,
  parameter logic [31:0] MEM_RD_ADDR = 32'h000C_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_write,
  input  logic [SRC_W-1:0] in_src,
  output logic             mem_rd_req,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rd_done,
  output logic             up_cpl_valid,
  output logic [1:0]       up_cpl_status,
  output logic [SRC_W-1:0] up_cpl_src
);

  typedef enum logic {INB_IDLE, INB_WAIT} inb_e;

  inb_e             state_q, state_d;
  logic             rd_req_d;
  logic             up_valid_d;
  logic [SRC_W-1:0] src_q;
  logic             accept;

  assign in_ready      = (state_q == INB_IDLE);
  assign accept        = in_valid && in_ready;
  assign mem_rd_addr   = MEM_RD_ADDR;
  assign up_cpl_status = CPL_UR;
  assign up_cpl_src    = src_q;

  always_comb begin
    state_d    = state_q;
    rd_req_d   = 1'b0;
    up_valid_d = 1'b0;
    if (accept) begin
      state_d  = INB_WAIT;
      rd_req_d = 1'b1;
    end
    if (state_q == INB_WAIT && mem_rd_done) begin
      state_d    = INB_IDLE;
      up_valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= INB_IDLE;
      mem_rd_req   <= 1'b0;
      up_cpl_valid <= 1'b0;
    end else begin
      state_q      <= state_d;
      mem_rd_req   <= rd_req_d;
      up_cpl_valid <= up_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (accept) src_q <= in_src;
  end

  // R10
  inb_write_as_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_write) |=> (mem_rd_req && mem_rd_addr == MEM_RD_ADDR));

  // R10
  inb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_write) |=> mem_rd_req);

  // R11
  inb_cpl_ur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_cpl_valid |-> (up_cpl_status == CPL_UR && in_ready));

endmodule

// File: rtl/io_cycle_router.sv
module io_cycle_router
  import io_route_pkg::*;
#(
  parameter int          AW          = 16,
  parameter int          DW          = 32,
  parameter int          WIN_LSB     = 12,
  parameter int          SRC_W       = 1,
  parameter logic [31:0] MEM_RD_ADDR = 32'h000C_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic [3:0]            req_be,
  input  logic                  req_write,
  input  logic [DW-1:0]         req_wdata,
  input  logic                  gfx_en,
  input  logic                  pcie_io_en,
  input  logic [AW-WIN_LSB-1:0] pcie_base,
  input  logic [AW-WIN_LSB-1:0] pcie_limit,
  output logic                  cfg_req,
  output logic                  gfx_req,
  output logic                  pcie_req,
  output logic                  legacy_req,
  output logic [AW-1:0]         fwd_addr,
  output logic [3:0]            fwd_be,
  output logic                  fwd_write,
  output logic [DW-1:0]         fwd_wdata,
  input  logic                  tgt_cpl_valid,
  input  logic [1:0]            tgt_cpl_status,
  input  logic [DW-1:0]         tgt_cpl_data,
  output logic                  cpl_valid,
  output logic [1:0]            cpl_status,
  output logic [DW-1:0]         cpl_rdata,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_write,
  input  logic [SRC_W-1:0]      in_src,
  output logic                  mem_rd_req,
  output logic [31:0]           mem_rd_addr,
  input  logic                  mem_rd_done,
  output logic                  up_cpl_valid,
  output logic [1:0]            up_cpl_status,
  output logic [SRC_W-1:0]      up_cpl_src
);

  logic            rst_meta_q, rst_sync_n;
  dest_e           dest;
  logic [DW-1:0]   cfg_q;
  logic            cfg_wr_en;
  logic [NSTB-1:0] strobe;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  io_addr_decoder #(
    .AW      (AW),
    .WIN_LSB (WIN_LSB)
  ) u_dec (
    .dw_addr    (req_addr[AW-1:2]),
    .be         (req_be),
    .cfg_enable (cfg_q[DW-1]),
    .gfx_en     (gfx_en),
    .pcie_io_en (pcie_io_en),
    .pcie_base  (pcie_base),
    .pcie_limit (pcie_limit),
    .dest       (dest)
  );

  io_cfg_addr_reg #(.DW(DW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (cfg_wr_en),
    .wdata (req_wdata),
    .q     (cfg_q)
  );

  io_req_tracker #(.AW(AW), .DW(DW)) u_trk (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_be         (req_be),
    .req_write      (req_write),
    .req_wdata      (req_wdata),
    .dest           (dest),
    .cfg_q          (cfg_q),
    .cfg_wr_en      (cfg_wr_en),
    .strobe         (strobe),
    .fwd_addr       (fwd_addr),
    .fwd_be         (fwd_be),
    .fwd_write      (fwd_write),
    .fwd_wdata      (fwd_wdata),
    .tgt_cpl_valid  (tgt_cpl_valid),
    .tgt_cpl_status (tgt_cpl_status),
    .tgt_cpl_data   (tgt_cpl_data),
    .cpl_valid      (cpl_valid),
    .cpl_status     (cpl_status),
    .cpl_rdata      (cpl_rdata)
  );

  assign cfg_req    = strobe[STB_CFG];
  assign gfx_req    = strobe[STB_GFX];
  assign pcie_req   = strobe[STB_PCIE];
  assign legacy_req = strobe[STB_LEGACY];

  io_inbound_conv #(
    .SRC_W       (SRC_W),
    .MEM_RD_ADDR (MEM_RD_ADDR)
  ) u_inb (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_write      (in_write),
    .in_src        (in_src),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_done   (mem_rd_done),
    .up_cpl_valid  (up_cpl_valid),
    .up_cpl_status (up_cpl_status),
    .up_cpl_src    (up_cpl_src)
  );

  // R4
  gfx_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gfx_req |-> $past(gfx_en));

  // R5
  pcie_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pcie_req |-> ($past(pcie_io_en) && $past(pcie_base) <= $past(pcie_limit)));

  // R3
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_req |-> $past(cfg_q[DW-1]));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (req_ready && in_ready && !cpl_valid && !mem_rd_req));

endmodule

// File: tb/sim_io_cycle_router.sv
`timescale 1ns/1ps
module sim_io_cycle_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        gfx_en, pcie_io_en;
  logic [3:0]  pcie_base, pcie_limit;
  logic        tgt_cpl_valid;
  logic [1:0]  tgt_cpl_status;
  logic [31:0] tgt_cpl_data;
  logic        in_valid, in_write;
  logic [0:0]  in_src;
  logic        mem_rd_done;

  logic        req_ready, cfg_req, gfx_req, pcie_req, legacy_req;
  logic [15:0] fwd_addr;
  logic [3:0]  fwd_be;
  logic        fwd_write;
  logic [31:0] fwd_wdata;
  logic        cpl_valid;
  logic [1:0]  cpl_status;
  logic [31:0] cpl_rdata;
  logic        in_ready, mem_rd_req, up_cpl_valid;
  logic [31:0] mem_rd_addr;
  logic [1:0]  up_cpl_status;
  logic [0:0]  up_cpl_src;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  localparam logic [3:0] S_NONE = 4'b0000, S_CFG = 4'b1000, S_GFX = 4'b0100,
                         S_PCIE = 4'b0010, S_LEG = 4'b0001;

  always #5 clk = ~clk;

  io_cycle_router u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
    .gfx_en(gfx_en), .pcie_io_en(pcie_io_en), .pcie_base(pcie_base), .pcie_limit(pcie_limit),
    .cfg_req(cfg_req), .gfx_req(gfx_req), .pcie_req(pcie_req), .legacy_req(legacy_req),
    .fwd_addr(fwd_addr), .fwd_be(fwd_be), .fwd_write(fwd_write), .fwd_wdata(fwd_wdata),
    .tgt_cpl_valid(tgt_cpl_valid), .tgt_cpl_status(tgt_cpl_status), .tgt_cpl_data(tgt_cpl_data),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_rdata(cpl_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write), .in_src(in_src),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_done(mem_rd_done),
    .up_cpl_valid(up_cpl_valid), .up_cpl_status(up_cpl_status), .up_cpl_src(up_cpl_src)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] stb();
    return {cfg_req, gfx_req, pcie_req, legacy_req};
  endfunction

  task automatic issue(input logic [15:0] a, input logic [3:0] be, input logic wr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_be = be; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // issues one request, checks the routing and finishes it with a success completion
  task automatic route(input logic [15:0] a, input logic [3:0] be, input logic wr,
                       input logic [31:0] d, input logic [3:0] exp, input string tag);
    logic [31:0] rd;
    rd = {16'hBEEF, a};
    issue(a, be, wr, d);
    chk(stb() == exp, tag, stb(), exp);
    if (exp != S_NONE) begin
      chk(fwd_addr == a && fwd_be == be && fwd_write == wr && fwd_wdata == d,
          "R8 forward untranslated", {fwd_addr, fwd_be}, {a, be});
      chk(!req_ready, "R9 ready low while pending", req_ready, 0);
      tgt_cpl_valid = 1'b1; tgt_cpl_status = 2'b00; tgt_cpl_data = rd;
      @(negedge clk);
      tgt_cpl_valid = 1'b0;
      chk(cpl_valid && cpl_status == 2'b00 && cpl_rdata == rd, "R9 completion relayed",
          {cpl_valid, cpl_rdata}, {1'b1, rd});
      chk(stb() == S_NONE && req_ready, "R9 strobe single pulse", {stb(), req_ready}, 5'b00001);
    end else begin
      chk(cpl_valid && cpl_status == 2'b00, "R2 local completion", {cpl_valid, cpl_status}, 3'b100);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 0; req_addr = 0; req_be = 0; req_write = 0; req_wdata = 0;
    gfx_en = 0; pcie_io_en = 0; pcie_base = 0; pcie_limit = 0;
    tgt_cpl_valid = 0; tgt_cpl_status = 0; tgt_cpl_data = 0;
    in_valid = 0; in_write = 0; in_src = 0; mem_rd_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && in_ready, "R1 ready after reset", {req_ready, in_ready}, 2'b11);
    chk(stb() == S_NONE && !cpl_valid && !mem_rd_req && !up_cpl_valid, "R1 outputs idle",
        {stb(), cpl_valid, mem_rd_req, up_cpl_valid}, 0);
    route(16'h0CF8, 4'hF, 1'b0, 0, S_NONE, "R1 cfg addr read");
    chk(cpl_rdata == 32'h0, "R1 cfg addr reg zero", cpl_rdata, 0);
  endtask

  task automatic t_cfg();
    route(16'h0CFC, 4'h1, 1'b0, 0, S_LEG, "R3 cfg data disabled goes legacy");
    route(16'h0CF8, 4'hF, 1'b1, 32'h8000_0A10, S_NONE, "R2 cfg addr write claimed");
    route(16'h0CF8, 4'hF, 1'b0, 0, S_NONE, "R2 cfg addr read claimed");
    chk(cpl_rdata == 32'h8000_0A10, "R2 cfg addr readback", cpl_rdata, 32'h8000_0A10);
    route(16'h0CF8, 4'h1, 1'b1, 32'h0, S_LEG, "R2 partial cfg addr not claimed");
    route(16'h0CF8, 4'hF, 1'b0, 0, S_NONE, "R2 partial write did not store");
    chk(cpl_rdata == 32'h8000_0A10, "R2 value kept after partial", cpl_rdata, 32'h8000_0A10);
    route(16'h0CFC, 4'h1, 1'b0, 0, S_CFG, "R3 cfg data byte0");
    route(16'h0CFC, 4'hC, 1'b1, 32'h1234_5678, S_CFG, "R3 cfg data upper bytes");
    route(16'h0CF8, 4'hF, 1'b1, 32'h0000_0A10, S_NONE, "R3 clear enable");
    route(16'h0CFC, 4'hF, 1'b0, 0, S_LEG, "R3 cfg data after clear");
  endtask

  task automatic t_gfx();
    gfx_en = 1'b1;
    route(16'h03B4, 4'h1, 1'b0, 0, S_GFX, "R4 gfx mono range");
    route(16'h03DC, 4'h8, 1'b1, 32'h5A, S_GFX, "R4 gfx top dword");
    route(16'h03BC, 4'h1, 1'b0, 0, S_LEG, "R4 gap between ranges");
    route(16'h03E0, 4'h1, 1'b0, 0, S_LEG, "R4 above range");
    gfx_en = 1'b0;
    route(16'h03C0, 4'h1, 1'b0, 0, S_LEG, "R4 gfx disabled");
  endtask

  task automatic t_pcie();
    pcie_io_en = 1'b1; pcie_base = 4'h2; pcie_limit = 4'h3;
    route(16'h2000, 4'hF, 1'b0, 0, S_PCIE, "R5 window base");
    route(16'h3FFC, 4'h8, 1'b1, 32'h77, S_PCIE, "R5 window limit end");
    route(16'h1FFC, 4'hF, 1'b0, 0, S_LEG, "R5 below window");
    route(16'h4000, 4'hF, 1'b0, 0, S_LEG, "R5 above window");
    pcie_io_en = 1'b0;
    route(16'h2000, 4'hF, 1'b0, 0, S_LEG, "R5 window disabled");
    pcie_io_en = 1'b1; pcie_base = 4'h5; pcie_limit = 4'h4;
    route(16'h5000, 4'hF, 1'b0, 0, S_LEG, "R5 inverted window base");
    route(16'h4000, 4'hF, 1'b0, 0, S_LEG, "R5 inverted window limit");
    route(16'h0080, 4'h1, 1'b0, 0, S_LEG, "R7 default route");
  endtask

  task automatic t_priority();
    pcie_io_en = 1'b1; pcie_base = 4'h0; pcie_limit = 4'h0; gfx_en = 1'b1;
    route(16'h03C0, 4'h1, 1'b0, 0, S_GFX, "R6 gfx over window");
    gfx_en = 1'b0;
    route(16'h03C0, 4'h1, 1'b0, 0, S_PCIE, "R6 window over default");
    route(16'h0CF8, 4'hF, 1'b1, 32'h8000_0000, S_NONE, "R6 cfg addr over window");
    route(16'h0CFC, 4'hF, 1'b0, 0, S_CFG, "R6 cfg data over window");
    route(16'h0CF8, 4'hF, 1'b1, 32'h0, S_NONE, "R6 clear enable");
    pcie_io_en = 1'b0;
  endtask

  task automatic t_nonposted();
    issue(16'h0084, 4'hF, 1'b1, 32'hCAFE_0001);
    chk(stb() == S_LEG, "R9 write forwarded", stb(), S_LEG);
    req_valid = 1'b1; req_addr = 16'h0088; req_be = 4'hF; req_write = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready && stb() == S_NONE && !cpl_valid, "R9 pending blocks new request",
          {req_ready, stb(), cpl_valid}, 0);
    end
    req_valid = 1'b0;
    tgt_cpl_valid = 1'b1; tgt_cpl_status = 2'b01; tgt_cpl_data = 32'h0;
    @(negedge clk);
    tgt_cpl_valid = 1'b0;
    chk(cpl_valid && cpl_status == 2'b01, "R9 destination status relayed",
        {cpl_valid, cpl_status}, 3'b101);
    @(negedge clk);
    chk(req_ready && !cpl_valid && stb() == S_NONE, "R9 held request ignored",
        {req_ready, cpl_valid, stb()}, 6'b100000);
    tgt_cpl_valid = 1'b1;
    @(negedge clk);
    tgt_cpl_valid = 1'b0;
    @(negedge clk);
    chk(!cpl_valid, "R9 stray completion ignored when idle", cpl_valid, 0);
  endtask

  task automatic inbound(input logic wr, input logic src);
    @(negedge clk);
    in_valid = 1'b1; in_write = wr; in_src = src;
    @(negedge clk);
    in_valid = 1'b0;
    chk(mem_rd_req && mem_rd_addr == 32'h000C_0000, "R10 memory read issued",
        {mem_rd_req, mem_rd_addr}, {1'b1, 32'h000C_0000});
    chk(!in_ready, "R10 inbound busy", in_ready, 0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!mem_rd_req && !up_cpl_valid, "R10 single read while pending", {mem_rd_req, up_cpl_valid}, 0);
    mem_rd_done = 1'b1;
    @(negedge clk);
    mem_rd_done = 1'b0;
    chk(up_cpl_valid && up_cpl_status == 2'b01 && up_cpl_src == src, "R11 UR completion",
        {up_cpl_valid, up_cpl_status, up_cpl_src}, {1'b1, 2'b01, src});
    @(negedge clk);
    chk(in_ready && !up_cpl_valid && !mem_rd_req, "R11 back to idle",
        {in_ready, up_cpl_valid, mem_rd_req}, 3'b100);
  endtask

  task automatic t_inbound();
    inbound(1'b1, 1'b1);
    inbound(1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cfg();
    t_gfx();
    t_pcie();
    t_priority();
    t_nonposted();
    t_inbound();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule